// File: doc/BRIEF.md
# Radix-4 Recoded Partial Product Generator

This block turns an unsigned M-bit multiplicand and an unsigned M-bit multiplier into the partial products that a separate summation network adds to form the full 2M-bit product. The multiplier is read two bits at a time. Each pair, together with a carry from the pair below it, picks one multiple of the multiplicand from the set {0, +N, +2N, -N}. The multiple 3N never appears. In its place a pair emits -N and passes a carry of one unit of its own weight upward, and the next pair adds that unit back in.

Because of this carry, the top pair can produce one more unit than its own weight holds. One extra partial product beyond the M/2 group outputs absorbs it. Every partial product leaves the block shifted to its weight, filled with zeros below that weight, and sign-extended over the full 2M-bit width. A negative multiple is already in two's complement form. The summation network therefore only has to add M/2+1 equal-width words modulo 2^(2M). No correction term is needed.

The recoding logic is purely combinational. A parameter places a register on the output, which is reset synchronously.

Top module: `booth_ppgen`

## Requirements
- R1: The sum of all M/2+1 partial products, taken modulo 2^(2M), equals the product of the multiplicand and the multiplier.
- R2: Partial product i, for i below M/2, has its low 2i bits equal to zero.
- R3: Partial product i, for i below M/2, is one of 0, N*4^i, 2N*4^i or -N*4^i, each taken modulo 2^(2M).
- R4: Group i reads multiplier bits 2i+1 and 2i and a carry c from group i-1, with c = 0 for group 0. Let v = bit(2i) + 2*bit(2i+1) + c. The group then emits 0 for v = 0, +N for v = 1, +2N for v = 2, -N with a carry out of 1 for v = 3, and 0 with a carry out of 1 for v = 4.
- R5: The final partial product (index M/2) equals N*2^M when the top group carries out, and zero otherwise.
- R6: With REG_OUT = 1, the outputs show the inputs that were sampled at the previous rising clock edge, and they do not follow input changes between edges. With REG_OUT = 0, the outputs are combinational.
- R7: While rst is high at a rising edge, every partial product is cleared to zero (REG_OUT = 1).
- R8: Partial product i occupies bits [i*2M +: 2M] of pp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mcand_i | input | M | Unsigned multiplicand N |
| mplier_i | input | M | Unsigned multiplier S |
| pp_o | output | (M/2+1)*2M | Packed partial products, index 0 in the lowest slice |

## Verification
The hardest case to reach is a carry that ripples through many groups. Only long runs of ones in the multiplier cause it, such as 0xFFFF. In that case every group above the lowest one recodes to zero, and the whole product rests on the lowest -N term plus the extra top partial product. The bench drives this pattern and several other hand-computed patterns and checks each slice. For M = 6 it also sweeps every operand pair, so that every combination of group bits and carry is met in every position.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    MAG_ZERO = 2'd0,
    MAG_ONE  = 2'd1,
    MAG_TWO  = 2'd2
  } mag_e;

  typedef struct packed {
    mag_e mag;
    logic neg;
  } pp_sel_t;
endpackage

// File: rtl/booth_group_sel.sv
module booth_group_sel
  import booth_pkg::*;
(
  input  logic [1:0] grp_i,
  input  logic       cin_i,
  output pp_sel_t    sel_o,
  output logic       cout_o
);
  // Value v = grp + cin in 0..4. v=3 becomes -1 with a carry, v=4 becomes 0 with a carry.
  always_comb begin
    sel_o  = '{mag: MAG_ZERO, neg: 1'b0};
    cout_o = 1'b0;
    unique case ({grp_i, cin_i})
      3'b000: sel_o = '{mag: MAG_ZERO, neg: 1'b0};
      3'b001,
      3'b010: sel_o = '{mag: MAG_ONE,  neg: 1'b0};
      3'b011,
      3'b100: sel_o = '{mag: MAG_TWO,  neg: 1'b0};
      3'b101,
      3'b110: begin
        sel_o  = '{mag: MAG_ONE, neg: 1'b1};
        cout_o = 1'b1;
      end
      3'b111: begin
        sel_o  = '{mag: MAG_ZERO, neg: 1'b0};
        cout_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/booth_pp_form.sv
module booth_pp_form
  import booth_pkg::*;
#(
  parameter int M   = 16,
  parameter int IDX = 0
) (
  input  logic [M-1:0]   n_i,
  input  pp_sel_t        sel_i,
  output logic [2*M-1:0] pp_o
);
  localparam int W     = 2 * M;
  localparam int SHIFT = 2 * IDX;

  logic [W-1:0] mag;
  logic [W-1:0] signed_mag;

  always_comb begin
    unique case (sel_i.mag)
      MAG_ONE: mag = {{M{1'b0}}, n_i};
      MAG_TWO: mag = {{(M-1){1'b0}}, n_i, 1'b0};
      default: mag = '0;
    endcase
    signed_mag = sel_i.neg ? (~mag + {{(W-1){1'b0}}, 1'b1}) : mag;
    pp_o       = signed_mag << SHIFT;
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_pkg::*;
#(
  parameter int M       = 16,
  parameter int REG_OUT = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [M-1:0]               mcand_i,
  input  logic [M-1:0]               mplier_i,
  output logic [(M/2+1)*2*M-1:0]     pp_o
);
  localparam int W   = 2 * M;
  localparam int NG  = M / 2;
  localparam int NPP = NG + 1;

  logic [NG:0]        carry;
  logic [NPP*W-1:0]   pp_comb;

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    pp_sel_t sel;

    booth_group_sel u_sel (
      .grp_i  (mplier_i[2*g +: 2]),
      .cin_i  (carry[g]),
      .sel_o  (sel),
      .cout_o (carry[g+1])
    );

    booth_pp_form #(.M(M), .IDX(g)) u_form (
      .n_i   (mcand_i),
      .sel_i (sel),
      .pp_o  (pp_comb[g*W +: W])
    );
  end

  // Extra partial product absorbs the top group's compensation unit.
  assign pp_comb[NG*W +: W] = carry[NG] ? {mcand_i, {M{1'b0}}} : '0;

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) pp_o <= '0;
      else     pp_o <= pp_comb;
    end
  end else begin : g_comb
    assign pp_o = pp_comb;
  end
endmodule

// File: rtl/booth_ppgen_chk.sv
module booth_ppgen_chk #(
  parameter int M       = 16,
  parameter int REG_OUT = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [M-1:0]           mcand_i,
  input logic [M-1:0]           mplier_i,
  input logic [(M/2+1)*2*M-1:0] pp_o
);
  localparam int W  = 2 * M;
  localparam int NG = M / 2;

  logic [M-1:0] a_q, b_q;
  logic         q_ok;
  logic [M-1:0] a_ref, b_ref;
  logic         ref_ok;
  logic [W-1:0] pp_sum;
  logic [W-1:0] prod_ref;

  always_ff @(posedge clk) begin
    a_q  <= mcand_i;
    b_q  <= mplier_i;
    q_ok <= !rst;
  end

  assign a_ref    = (REG_OUT != 0) ? a_q : mcand_i;
  assign b_ref    = (REG_OUT != 0) ? b_q : mplier_i;
  assign ref_ok   = (REG_OUT != 0) ? q_ok : 1'b1;
  assign prod_ref = {{M{1'b0}}, a_ref} * {{M{1'b0}}, b_ref};

  always_comb begin
    pp_sum = '0;
    for (int i = 0; i <= NG; i++) pp_sum = pp_sum + pp_o[i*W +: W];
  end

  // R1
  sum_matches_product_chk: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> (pp_sum == prod_ref));

  for (genvar i = 0; i < NG; i++) begin : g_pp
    logic [W-1:0] one_n;
    logic [W-1:0] slice;
    assign one_n = {{M{1'b0}}, a_ref} << (2*i);
    assign slice = pp_o[i*W +: W];

    if (i > 0) begin : g_low
      // R2
      low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ref_ok |-> (slice[2*i-1:0] == '0));
    end

    // R3
    value_set_chk: assert property (@(posedge clk) disable iff (rst)
      ref_ok |-> (slice == '0 || slice == one_n || slice == (one_n << 1) ||
                  slice == (~one_n + 1'b1)));
  end

  // R5
  top_extra_chk: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> (pp_o[NG*W +: W] == '0 || pp_o[NG*W +: W] == {a_ref, {M{1'b0}}}));

  if (REG_OUT != 0) begin : g_rst
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (pp_o == '0));
  end
endmodule

bind booth_ppgen booth_ppgen_chk #(.M(M), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .pp_o     (pp_o)
);

// File: tb/booth_ppgen_test.sv
module booth_ppgen_test;
  localparam int CLK_PERIOD = 10;
  localparam int MA = 16, WA = 32, NA = 9;
  localparam int MB = 6,  WB = 12, NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MA-1:0] a16 = '0, b16 = '0;
  logic [MB-1:0] a6 = '0, b6 = '0;
  logic [NA*WA-1:0] pp16;
  logic [NB*WB-1:0] pp6;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [15:0] a; logic [15:0] b; } item_t;
  item_t q16[$];
  item_t q6[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_ppgen #(.M(MA), .REG_OUT(1)) uut (
    .clk(clk), .rst(rst), .mcand_i(a16), .mplier_i(b16), .pp_o(pp16));

  booth_ppgen #(.M(MB), .REG_OUT(1)) uut6 (
    .clk(clk), .rst(rst), .mcand_i(a6), .mplier_i(b6), .pp_o(pp6));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WA-1:0] s16(input int i);
    return pp16[i*WA +: WA];
  endfunction

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a16 = a; b16 = b;
    q16.push_back('{a: a, b: b});
  endtask

  task automatic drive6(input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    a6 = a; b6 = b;
    q6.push_back('{a: {10'd0, a}, b: {10'd0, b}});
  endtask

  // Monitor for M = 16: R1 sum, R2 alignment (R8 slicing), R3 value set, R5 top slice
  always @(posedge clk) begin
    #1;
    if (!rst && q16.size() > 0) begin
      item_t it;
      logic [WA-1:0] sum, exp, one, sl;
      bit al_ok, set_ok;
      it = q16.pop_front();
      exp = {16'd0, it.a} * {16'd0, it.b};
      sum = '0;
      al_ok = 1; set_ok = 1;
      for (int i = 0; i < NA; i++) sum += s16(i);
      for (int i = 0; i < NA-1; i++) begin
        sl  = s16(i);
        one = {16'd0, it.a} << (2*i);
        if (i > 0 && (sl & ((32'd1 << (2*i)) - 1)) != 0) al_ok = 0;
        if (!(sl == 0 || sl == one || sl == (one << 1) || sl == (~one + 1))) set_ok = 0;
      end
      chk(sum == exp, "R1 sum m=16", sum, exp);
      chk(al_ok, "R2 low zeros m=16", pp16[63:0], 64'd0);
      chk(set_ok, "R3 value set m=16", pp16[63:0], 64'd0);
      chk(s16(NA-1) == 0 || s16(NA-1) == {it.a, 16'd0}, "R5 top slice m=16",
          s16(NA-1), {16'd0, it.a, 16'd0});
    end
  end

  // Monitor for M = 6: R1 sum
  always @(posedge clk) begin
    #1;
    if (!rst && q6.size() > 0) begin
      item_t it;
      logic [WB-1:0] sum, exp;
      it = q6.pop_front();
      exp = {6'd0, it.a[5:0]} * {6'd0, it.b[5:0]};
      sum = '0;
      for (int i = 0; i < NB; i++) sum += pp6[i*WB +: WB];
      chk(sum == exp, "R1 sum m=6", {52'd0, sum}, {52'd0, exp});
    end
  end

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset clears the outputs even with nonzero inputs
    a16 = 16'hFFFF; b16 = 16'h0003; a6 = 6'h3F; b6 = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    chk(pp16 == '0, "R7 reset m=16", pp16[63:0], 64'd0);
    chk(pp6 == '0, "R7 reset m=6", {16'd0, pp6}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R4: 3 -> -N in group 0, +N compensation in group 1 (slices per R8)
    drive16(16'd5, 16'd3);
    settle();
    chk(s16(0) == 32'hFFFF_FFFB, "R4 grp0 -N", s16(0), 32'hFFFF_FFFB);
    chk(s16(1) == 32'd20, "R4 grp1 comp +N", s16(1), 32'd20);
    chk(s16(2) == 32'd0, "R4 grp2 zero", s16(2), 32'd0);

    // R6: input change between edges does not reach the output
    @(negedge clk);
    a16 = 16'd7; b16 = 16'd7;
    #1;
    chk(s16(0) == 32'hFFFF_FFFB, "R6 held until edge", s16(0), 32'hFFFF_FFFB);
    settle();
    chk(s16(0) == 32'hFFFF_FFF9, "R6 updated after edge", s16(0), 32'hFFFF_FFF9);

    // R5: all-ones multiplier ripples the carry to the extra slice
    drive16(16'h1234, 16'hFFFF);
    settle();
    chk(s16(0) == 32'hFFFF_EDCC, "R4 lowest -N", s16(0), 32'hFFFF_EDCC);
    chk(s16(4) == 32'd0, "R4 v=4 gives zero", s16(4), 32'd0);
    chk(s16(7) == 32'd0, "R4 top group zero", s16(7), 32'd0);
    chk(s16(8) == 32'h1234_0000, "R5 extra slice N<<M", s16(8), 32'h1234_0000);

    // R4: pattern 10 in every group gives +2N without carry
    drive16(16'hFFFF, 16'hAAAA);
    settle();
    chk(s16(3) == (32'h1FFFE << 6), "R4 +2N grp3", s16(3), 32'h1FFFE << 6);
    chk(s16(8) == 32'd0, "R5 no carry extra zero", s16(8), 32'd0);

    // R4: group 0 = 10 -> +2N, group 1 = 01 -> +N
    drive16(16'h0101, 16'h0006);
    settle();
    chk(s16(0) == 32'h0202, "R4 grp0 +2N", s16(0), 32'h0202);
    chk(s16(1) == 32'h0404, "R4 grp1 +N", s16(1), 32'h0404);

    // R4: multiplier top bit alone -> group 7 = 10 -> +2N << 14
    drive16(16'h00FF, 16'h8000);
    settle();
    chk(s16(7) == (32'h01FE << 14), "R4 top grp +2N", s16(7), 32'h01FE << 14);
    chk(s16(8) == 32'd0, "R5 top no carry", s16(8), 32'd0);

    // R1: exhaustive sweep for M = 6
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        drive6(a[5:0], b[5:0]);

    // R1: random and corner operands for M = 16
    drive16(16'h0000, 16'hFFFF);
    drive16(16'hFFFF, 16'hFFFF);
    drive16(16'hFFFF, 16'h0001);
    drive16(16'h8000, 16'h5555);
    for (int k = 0; k < 3000; k++)
      drive16(16'($urandom), 16'($urandom));

    repeat (3) @(posedge clk);
    #2;
    chk(q16.size() == 0 && q6.size() == 0, "R1 scoreboard drained",
        64'(q16.size() + q6.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule